// File: doc/BRIEF.md
# External and Pin-Change Interrupt Unit

This block watches one dedicated external interrupt input and twelve general-purpose pins. The dedicated input has a sense mode chosen by a 2-bit control field. In level mode it requests service for as long as it is held low. In the other modes it sets a sticky flag on any change, on a falling edge or on a rising edge. The twelve pins form two pin-change groups, eight pins and four pins. Each group has its own mask, and a group sets its sticky flag when any unmasked pin of that group toggles in either direction. Detection works on the pin value alone, so software that drives a pin it owns as an output can raise an interrupt on purpose.

Every pin passes through a two-stage synchroniser, and the previous synchronised value is kept for comparison. A flag is cleared either by a write-one-to-clear strobe or by the per-source acknowledge strobe. The block gives one combined request with the identity of the highest-priority pending source. It also gives a combinational wake output that needs no clock, so it still works when the sampling clock is gated off. Edge detection, by contrast, needs that clock. All pins and controls are plain level signals; there is no data stream and no handshake.

Top module: `xint_unit`

## Requirements
- R1: After reset, with `ext_pin` high and every `pc_pin` low, `flags` is 3'b000, `irq_req` is 0 and `wake` is 0.
- R2: `ext_mode` encodings are 2'b00 low level, 2'b01 any change, 2'b10 falling edge and 2'b11 rising edge. In the three edge modes a matching transition on `ext_pin` sets `flags[0]`, and a transition that does not match leaves it clear.
- R3: In level mode with `ext_en` high, `irq_req` is high with `irq_id` 0 while the synchronised `ext_pin` is low. `flags[0]` is never set in this mode, `ack[0]` does not remove the request, and the request drops once the pin is high again.
- R4: A toggle in either direction on any of `pc_pin[7:0]` whose `pc_mask0` bit is 1 sets `flags[1]`. A toggle on a pin whose mask bit is 0 leaves `flags[1]` clear.
- R5: A toggle in either direction on any of `pc_pin[11:8]` whose `pc_mask1` bit (pin index minus 8) is 1 sets `flags[2]`. A toggle on a pin whose mask bit is 0 leaves `flags[2]` clear.
- R6: The flags are sticky. Bit 0 is the external input, bit 1 is group 0 and bit 2 is group 1. A flag is cleared one cycle after a 1 on the same bit of `flag_clr` or `ack`, and a new event in the same cycle wins over the clear.
- R7: A source is pending when its flag is set and its enable (`ext_en`, `pc_en[0]`, `pc_en[1]`) is high. In level mode the external source is pending while its level is active. A flag is set whatever its enable. `irq_req` is the OR of the pending sources. `irq_id` is 0 for the external input, 1 for group 0 and 2 for group 1, with the external input taking priority over group 0, and group 0 over group 1.
- R8: `wake` is combinational and needs no clock. It is high while `ext_en` is high, the mode is level and `ext_pin` is low. It is also high while any unmasked pin of an enabled group differs from its last latched value.
- R9: A low pulse on `ext_pin` in level mode that ends before it is sampled raises `wake` but produces no request and no flag.
- R10: An edge or toggle changes `flags` on the third rising clock edge after the pin changes, and not earlier: two synchroniser stages, then the compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | Dedicated external interrupt input |
| ext_en | input | 1 | Enable for the external source |
| ext_mode | input | 2 | Sense mode of the external input |
| pc_pin | input | 12 | General pins; [7:0] group 0, [11:8] group 1 |
| pc_mask0 | input | 8 | Per-pin mask for group 0 |
| pc_mask1 | input | 4 | Per-pin mask for group 1 |
| pc_en | input | 2 | Group enables, bit g for group g |
| flag_clr | input | 3 | Write-one-to-clear strobes for the flags |
| ack | input | 3 | Per-source interrupt acknowledge strobes |
| flags | output | 3 | Sticky flags: ext, group 0, group 1 |
| irq_req | output | 1 | Combined interrupt request |
| irq_id | output | 2 | Highest-priority pending source |
| wake | output | 1 | Asynchronous wake indication |

## Verification
The assertions take for granted that at most one acknowledge strobe is high in any cycle. They also assume that `ext_mode` holds steady across the cycle in which an external event is taken. The stimulus acknowledges only one source at a time and changes the mode only after the flags have been cleared. Pins are driven on falling clock edges. Apart from the deliberate short pulse, every level is held for at least three cycles, so that every transition crosses the synchroniser cleanly.

// File: rtl/xint_pkg.sv
package xint_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_GRP0 = 2'd1,
    SRC_GRP1 = 2'd2
  } src_e;

  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned NUM_GRP = 2;

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= {W{RST_VAL}};
      cur    <= {W{RST_VAL}};
      prev   <= {W{RST_VAL}};
    end else begin
      stage1 <= din;
      cur    <= stage1;
      prev   <= cur;
    end
  end
endmodule

// File: rtl/xint_sense.sv
module xint_sense
  import xint_pkg::*;
(
  input  logic   cur,
  input  logic   prev,
  input  logic   raw,
  input  logic   en,
  input  sense_e mode,
  output logic   event_hit,
  output logic   level_req,
  output logic   level_wake
);
  logic fell, rose;

  assign fell = prev & ~cur;
  assign rose = ~prev & cur;

  always_comb begin
    unique case (mode)
      SENSE_ANY:  event_hit = fell | rose;
      SENSE_FALL: event_hit = fell;
      SENSE_RISE: event_hit = rose;
      default:    event_hit = 1'b0;
    endcase
  end

  assign level_req  = en & (mode == SENSE_LOW) & ~cur;
  assign level_wake = en & (mode == SENSE_LOW) & ~raw;
endmodule

// File: rtl/xint_grp.sv
module xint_grp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] mask,
  output logic         toggled,
  output logic         differs
);
  assign toggled = |((cur ^ prev) & mask);
  assign differs = |((raw ^ prev) & mask);
endmodule

// File: rtl/xint_arb.sv
module xint_arb
  import xint_pkg::*;
(
  input  logic [NUM_SRC-1:0] pending,
  output logic               req,
  output logic [1:0]         id
);
  assign req = |pending;

  always_comb begin
    id = SRC_EXT;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (pending[k]) id = 2'(k);
    end
  end
endmodule

// File: rtl/xint_unit.sv
module xint_unit
  import xint_pkg::*;
#(
  parameter int unsigned G0_W = 8,
  parameter int unsigned G1_W = 4,
  localparam int unsigned PIN_W = G0_W + G1_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_pin,
  input  logic                ext_en,
  input  logic [1:0]          ext_mode,
  input  logic [PIN_W-1:0]    pc_pin,
  input  logic [G0_W-1:0]     pc_mask0,
  input  logic [G1_W-1:0]     pc_mask1,
  input  logic [NUM_GRP-1:0]  pc_en,
  input  logic [NUM_SRC-1:0]  flag_clr,
  input  logic [NUM_SRC-1:0]  ack,
  output logic [NUM_SRC-1:0]  flags,
  output logic                irq_req,
  output logic [1:0]          irq_id,
  output logic                wake
);
  logic             ext_cur, ext_prev;
  logic [PIN_W-1:0] pin_cur, pin_prev;
  logic             ext_event, ext_level, ext_lwake;
  logic [NUM_GRP-1:0] grp_toggle, grp_differs;
  logic [NUM_SRC-1:0] set_vec, clr_vec, pending;
  sense_e           mode_q;

  assign mode_q = sense_e'(ext_mode);

  xint_sync #(.W(1), .RST_VAL(1'b1)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_pin), .cur(ext_cur), .prev(ext_prev)
  );

  xint_sync #(.W(PIN_W), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .din(pc_pin), .cur(pin_cur), .prev(pin_prev)
  );

  xint_sense u_sense (
    .cur(ext_cur), .prev(ext_prev), .raw(ext_pin), .en(ext_en), .mode(mode_q),
    .event_hit(ext_event), .level_req(ext_level), .level_wake(ext_lwake)
  );

  xint_grp #(.W(G0_W)) u_grp0 (
    .cur(pin_cur[G0_W-1:0]), .prev(pin_prev[G0_W-1:0]),
    .raw(pc_pin[G0_W-1:0]), .mask(pc_mask0),
    .toggled(grp_toggle[0]), .differs(grp_differs[0])
  );

  xint_grp #(.W(G1_W)) u_grp1 (
    .cur(pin_cur[PIN_W-1:G0_W]), .prev(pin_prev[PIN_W-1:G0_W]),
    .raw(pc_pin[PIN_W-1:G0_W]), .mask(pc_mask1),
    .toggled(grp_toggle[1]), .differs(grp_differs[1])
  );

  assign set_vec = {grp_toggle, ext_event};
  assign clr_vec = flag_clr | ack;

  generate
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flags[k] <= 1'b0;
        else if (set_vec[k]) flags[k] <= 1'b1;
        else if (clr_vec[k]) flags[k] <= 1'b0;
      end
    end
  endgenerate

  assign pending[SRC_EXT]  = ext_level | (ext_en & flags[SRC_EXT]);
  assign pending[SRC_GRP0] = pc_en[0] & flags[SRC_GRP0];
  assign pending[SRC_GRP1] = pc_en[1] & flags[SRC_GRP1];

  xint_arb u_arb (
    .pending(pending), .req(irq_req), .id(irq_id)
  );

  assign wake = ext_lwake | |(pc_en & grp_differs);
endmodule

// File: rtl/xint_unit_chk.sv
module xint_unit_chk
  import xint_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ext_pin,
  input logic       ext_en,
  input logic [1:0] ext_mode,
  input logic [1:0] pc_en,
  input logic [2:0] flag_clr,
  input logic [2:0] ack,
  input logic [2:0] flags,
  input logic       irq_req,
  input logic [1:0] irq_id,
  input logic       wake
);
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack)); // R6

  AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(ext_mode) != SENSE_LOW); // R3

  AST_STICKY_GRP0: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] && !flag_clr[1] && !ack[1] |=> flags[1]); // R6

  AST_REQ_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (ext_en || (pc_en[0] && flags[1]) || (pc_en[1] && flags[2]))); // R7

  AST_EXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en && flags[0] |-> irq_req && irq_id == SRC_EXT); // R7

  AST_WAKE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en && ext_mode == SENSE_LOW && !ext_pin |-> wake); // R8
endmodule

bind xint_unit xint_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_en(ext_en),
  .ext_mode(ext_mode), .pc_en(pc_en), .flag_clr(flag_clr), .ack(ack),
  .flags(flags), .irq_req(irq_req), .irq_id(irq_id), .wake(wake)
);

// File: tb/xint_unit_tb.sv
`timescale 1ns/1ps
module xint_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_pin = 1'b1;
  logic        ext_en = 1'b0;
  logic [1:0]  ext_mode = 2'b00;
  logic [11:0] pc_pin = '0;
  logic [7:0]  pc_mask0 = '0;
  logic [3:0]  pc_mask1 = '0;
  logic [1:0]  pc_en = '0;
  logic [2:0]  flag_clr = '0;
  logic [2:0]  ack = '0;
  logic [2:0]  flags;
  logic        irq_req;
  logic [1:0]  irq_id;
  logic        wake;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xint_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_en(ext_en),
    .ext_mode(ext_mode), .pc_pin(pc_pin), .pc_mask0(pc_mask0),
    .pc_mask1(pc_mask1), .pc_en(pc_en), .flag_clr(flag_clr), .ack(ack),
    .flags(flags), .irq_req(irq_req), .irq_id(irq_id), .wake(wake)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic pulse_clr(input logic [2:0] c, input logic [2:0] a);
    flag_clr = c;
    ack = a;
    tick(1);
    flag_clr = '0;
    ack = '0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1 flags", 4'(flags), 4'd0);
    check("R1 irq_req", 4'(irq_req), 4'd0);
    check("R1 wake", 4'(wake), 4'd0);

    // R4 / R5 / R8 / R10: every pin, masked in and out, both directions
    pc_en = 2'b11;
    for (int i = 0; i < 12; i++) begin
      for (int m = 0; m < 2; m++) begin
        logic [11:0] full;
        logic e0, e1;
        full = 12'hFFF;
        if (m == 0) full[i] = 1'b0;
        pc_mask0 = full[7:0];
        pc_mask1 = full[11:8];
        e0 = (i < 8) && (m == 1);
        e1 = (i >= 8) && (m == 1);
        pc_pin[i] = ~pc_pin[i];
        #0.5;
        check("R8 wake on pin change", 4'(wake), 4'(m));
        tick(2);
        check("R10 no flag before third edge", 4'(flags), 4'd0);
        tick(1);
        check("R4 group0 flag", 4'(flags[1]), 4'(e0));
        check("R5 group1 flag", 4'(flags[2]), 4'(e1));
        check("R7 request", 4'(irq_req), 4'(e0 | e1));
        check("R8 wake cleared", 4'(wake), 4'd0);
        pulse_clr(3'b110, 3'b000);
        check("R6 write-one clear", 4'(flags), 4'd0);
      end
    end
    pc_en = 2'b00;

    // R2: edge modes on the external input
    ext_en = 1'b1;
    for (int md = 1; md < 4; md++) begin
      ext_mode = 2'(md);
      for (int dir = 0; dir < 2; dir++) begin
        logic ex;
        ex = (md == 1) || (md == 2 && dir == 0) || (md == 3 && dir == 1);
        ext_pin = (dir == 1);
        tick(3);
        check("R2 ext edge flag", 4'(flags[0]), 4'(ex));
        check("R7 ext request", 4'(irq_req), 4'(ex));
        pulse_clr(3'b000, 3'b001);
        check("R6 ack clears", 4'(flags[0]), 4'd0);
      end
    end

    // R3: level mode
    ext_mode = 2'b00;
    ext_pin = 1'b0;
    #0.5;
    check("R8 wake on low level", 4'(wake), 4'd1);
    tick(3);
    check("R3 level request", 4'(irq_req), 4'd1);
    check("R3 level id", 4'(irq_id), 4'd0);
    check("R3 no flag", 4'(flags[0]), 4'd0);
    pulse_clr(3'b000, 3'b001);
    check("R3 ack ignored", 4'(irq_req), 4'd1);
    ext_pin = 1'b1;
    tick(3);
    check("R3 request drops", 4'(irq_req), 4'd0);
    ext_en = 1'b0;
    ext_pin = 1'b0;
    tick(3);
    check("R7 disabled level", 4'(irq_req), 4'd0);
    check("R8 disabled no wake", 4'(wake), 4'd0);
    ext_pin = 1'b1;
    ext_en = 1'b1;
    tick(3);

    // R9: short low pulse between edges
    ext_pin = 1'b0;
    #0.5;
    check("R9 wake during pulse", 4'(wake), 4'd1);
    #0.5;
    ext_pin = 1'b1;
    tick(4);
    check("R9 no request", 4'(irq_req), 4'd0);
    check("R9 no flag", 4'(flags), 4'd0);

    // R7: enable gating and priority
    ext_mode = 2'b10;
    pc_mask0 = 8'hFF;
    pc_mask1 = 4'hF;
    pc_en = 2'b00;
    pc_pin[1] = ~pc_pin[1];
    tick(3);
    check("R7 flag without enable", 4'(flags), 4'b0010);
    check("R7 gated request", 4'(irq_req), 4'd0);
    pc_en = 2'b01;
    #0.5;
    check("R7 enabled request", 4'(irq_req), 4'd1);
    check("R7 group0 id", 4'(irq_id), 4'd1);
    tick(0);
    pulse_clr(3'b010, 3'b000);
    pc_en = 2'b11;
    ext_pin = 1'b0;
    pc_pin[0] = ~pc_pin[0];
    pc_pin[8] = ~pc_pin[8];
    tick(3);
    check("R7 all flags", 4'(flags), 4'b0111);
    check("R7 ext first", 4'(irq_id), 4'd0);
    pulse_clr(3'b000, 3'b001);
    check("R7 group0 next", 4'(irq_id), 4'd1);
    pulse_clr(3'b000, 3'b010);
    check("R7 group1 last", 4'(irq_id), 4'd2);
    check("R7 still requesting", 4'(irq_req), 4'd1);
    pulse_clr(3'b000, 3'b100);
    check("R6 all cleared", 4'(flags), 4'd0);
    check("R7 request idle", 4'(irq_req), 4'd0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule